// File: doc/BRIEF.md
# GPIO Controller with Edge-Detect Interrupts

This block is a 28-line general-purpose I/O controller that sits on a simple 32-bit register bus. Software configures each line as an input or an output. It drives output lines through a latch that only separate set and clear registers can change. It reads back the synchronized pin levels at any time. The pad side is modelled as an output vector and an output-enable vector, and input pins pass through a two-flop synchronizer.

Each line can capture rising transitions, falling transitions, or both. A captured transition sets a sticky status bit, and only a write of 1 to that bit clears it. Lines 0 to 10 each raise their own interrupt output. Lines 11 to 27 share one combined interrupt output. A further register is plain read/write storage for an alternate-function selection and has no effect on the pins.

The bus has a select, a write strobe, a byte address, write data and read data. Read data is combinational from the address during a read, and it is zero when no read is in progress. A write takes effect at the clock edge that ends its cycle.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the direction, output latch, both edge enables, edge status and alternate-function registers are zero. As a result pin_oe_o, pin_o and every interrupt output are 0.
- R2: Offset 0x00 is read-only and returns the pin levels. A pin change becomes readable after exactly two rising clock edges. Writes to 0x00 change nothing.
- R3: Offset 0x04 is the read/write direction register. A bit of 1 makes the line an output, and pin_oe_o equals this register.
- R4: A write to offset 0x08 sets each latch bit written as 1. A write to offset 0x0C clears each latch bit written as 1. Bits written as 0 are left alone. pin_o equals the latch, and both offsets read as zero.
- R5: Offsets 0x10 and 0x14 are the read/write rising-edge and falling-edge enables. An enabled transition of a pin level sets its bit in the status register. With both enables set, either transition sets the bit. The status bit is visible three rising edges after the pin changes.
- R6: The status register at offset 0x18 is sticky. Writing 1 to a bit clears it, writing 0 has no effect, and writing all ones clears every pending bit.
- R7: If a new enabled transition is detected in the same cycle as a write that clears that status bit, the bit stays set.
- R8: Transitions are detected on the pin level whatever the line's direction, so an output line that toggles its own pin is detected.
- R9: irq_low_o[i] equals status bit i for i from 0 to 10. irq_high_o is the OR of status bits 11 to 27.
- R10: Offset 0x1C is read/write storage and changes neither pin_o nor pin_oe_o.
- R11: Reads of unmapped offsets return zero, and writes to them change no register. Bits 31 to 28 of every register read as zero, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when not reading |
| pin_i | input | 28 | Pad input levels |
| pin_o | output | 28 | Pad output values |
| pin_oe_o | output | 28 | Pad output enables |
| irq_low_o | output | 11 | Per-line interrupts for lines 0 to 10 |
| irq_high_o | output | 1 | Combined interrupt for lines 11 to 27 |

## Verification
The results fall due at different times. A register write is visible at the first rising edge after it is issued, and a pin change is readable after two edges. A status bit and its interrupt follow the pin change by three edges, and read data is valid in the same cycle as the read. The bench keeps a cycle-level model that tracks the pin pipeline and the register state at each rising edge, and it compares every output on each falling edge. Because of this, every one of these latencies is checked at the exact cycle it falls due. Directed checks also cover the case where a clear collides with a new edge, loop-back detection on an output line, and the split of interrupts between the dedicated lines and the shared line.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_LVL  = 'h00;
  localparam int unsigned OFF_DIR  = 'h04;
  localparam int unsigned OFF_SET  = 'h08;
  localparam int unsigned OFF_CLR  = 'h0C;
  localparam int unsigned OFF_RISE = 'h10;
  localparam int unsigned OFF_FALL = 'h14;
  localparam int unsigned OFF_STAT = 'h18;
  localparam int unsigned OFF_ALT  = 'h1C;
endpackage

// File: rtl/gpio_ec_sync.sv
module gpio_ec_sync #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ec_edge.sv
module gpio_ec_edge #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] prev_q, stat_q, hit;

  assign hit = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | hit; // new edge wins over clear
    end
  end

  assign stat_o = stat_q;

  p_edge_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(hit)) == $past(hit)));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
  p_clear_collide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & hit) != '0) |=> ((stat_q & $past(clr_i & hit)) == $past(clr_i & hit)));
endmodule

// File: rtl/gpio_ec_regs.sv
module gpio_ec_regs
  import gpio_ec_pkg::*;
#(
  parameter int unsigned W      = 28,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      lvl_i,
  input  logic [W-1:0]      stat_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      rise_o,
  output logic [W-1:0]      fall_o,
  output logic [W-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD = DATA_W - W;

  logic [W-1:0] dir_q, out_q, rise_q, fall_q, alt_q, wd, rd;
  logic wr_en, rd_en, mapped;
  logic unused_wd;

  assign wd        = wdata_i[W-1:0];
  assign unused_wd = ^wdata_i[DATA_W-1:W];
  assign wr_en     = sel_i & wr_i;
  assign rd_en     = sel_i & ~wr_i;

  always_comb begin
    mapped = 1'b1;
    rd     = '0;
    case (addr_i)
      ADDR_W'(OFF_LVL):  rd = lvl_i;
      ADDR_W'(OFF_DIR):  rd = dir_q;
      ADDR_W'(OFF_SET),
      ADDR_W'(OFF_CLR):  rd = '0;
      ADDR_W'(OFF_RISE): rd = rise_q;
      ADDR_W'(OFF_FALL): rd = fall_q;
      ADDR_W'(OFF_STAT): rd = stat_i;
      ADDR_W'(OFF_ALT):  rd = alt_q;
      default:           mapped = 1'b0;
    endcase
  end

  assign rdata_o = rd_en ? {{PAD{1'b0}}, rd} : '0;
  assign clr_o   = (wr_en && addr_i == ADDR_W'(OFF_STAT)) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else if (wr_en) begin
      case (addr_i)
        ADDR_W'(OFF_DIR):  dir_q  <= wd;
        ADDR_W'(OFF_SET):  out_q  <= out_q | wd;
        ADDR_W'(OFF_CLR):  out_q  <= out_q & ~wd;
        ADDR_W'(OFF_RISE): rise_q <= wd;
        ADDR_W'(OFF_FALL): fall_q <= wd;
        ADDR_W'(OFF_ALT):  alt_q  <= wd;
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  p_set_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == ADDR_W'(OFF_SET)) |=> ((out_q & $past(wd)) == $past(wd)));
  p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == ADDR_W'(OFF_CLR)) |=> ((out_q & $past(wd)) == '0));
  p_unmapped_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !mapped) |=> ($stable(dir_q) && $stable(out_q) && $stable(rise_q)
                            && $stable(fall_q) && $stable(alt_q)));
  p_unmapped_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !mapped) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ec_pkg::*;
#(
  parameter int unsigned NPIN    = 28,
  parameter int unsigned NDIRECT = 11,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NPIN-1:0]    pin_i,
  output logic [NPIN-1:0]    pin_o,
  output logic [NPIN-1:0]    pin_oe_o,
  output logic [NDIRECT-1:0] irq_low_o,
  output logic               irq_high_o
);
  logic [NPIN-1:0] lvl, stat, rise, fall, clr;

  gpio_ec_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  gpio_ec_regs #(.W(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .lvl_i(lvl), .stat_i(stat),
    .dir_o(pin_oe_o), .out_o(pin_o), .rise_o(rise), .fall_o(fall),
    .clr_o(clr), .rdata_o(bus_rdata_o)
  );

  gpio_ec_edge #(.W(NPIN)) u_edge (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_en_i(rise), .fall_en_i(fall),
    .clr_i(clr), .stat_o(stat)
  );

  for (genvar i = 0; i < NDIRECT; i++) begin : g_irq
    assign irq_low_o[i] = stat[i];
  end
  assign irq_high_o = |stat[NPIN-1:NDIRECT];

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (pin_oe_o == '0 && pin_o == '0) || rst_ni);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  localparam int N = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] ext = '0, pin, pout, poe;
  logic [10:0] irq_low;
  logic        irq_high;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign pin = (poe & pout) | (~poe & ext);

  gpio_edge_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin), .pin_o(pout), .pin_oe_o(poe),
    .irq_low_o(irq_low), .irq_high_o(irq_high)
  );

  // reference model
  logic [N-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_alt, m_s1, m_lvl, m_prv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
      m_alt = '0; m_s1 = '0; m_lvl = '0; m_prv = '0;
    end else begin
      logic [N-1:0] hit, clrm, wd;
      wd   = wdata[N-1:0];
      hit  = (m_lvl & ~m_prv & m_rise) | (~m_lvl & m_prv & m_fall);
      clrm = (sel && wr && addr == 8'h18) ? wd : '0;
      m_stat = (m_stat & ~clrm) | hit;
      m_prv = m_lvl; m_lvl = m_s1; m_s1 = pin;
      if (sel && wr) begin
        case (addr)
          8'h04: m_dir = wd;
          8'h08: m_out = m_out | wd;
          8'h0C: m_out = m_out & ~wd;
          8'h10: m_rise = wd;
          8'h14: m_fall = wd;
          8'h1C: m_alt = wd;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [N-1:0] v;
    if (!(sel && !wr)) return '0;
    case (addr)
      8'h00: v = m_lvl;
      8'h04: v = m_dir;
      8'h10: v = m_rise;
      8'h14: v = m_fall;
      8'h18: v = m_stat;
      8'h1C: v = m_alt;
      default: v = '0;
    endcase
    return {4'b0, v};
  endfunction

  function automatic string rd_tag();
    case (addr)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08, 8'h0C: return "R4";
      8'h10, 8'h14: return "R5";
      8'h18: return "R6";
      8'h1C: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 pin_oe", 32'(poe), 32'(m_dir));
      check("R4 pin_o", 32'(pout), 32'(m_out));
      check("R9 irq_low", 32'(irq_low), 32'(m_stat[10:0]));
      check("R9 irq_high", 32'(irq_high), 32'(|m_stat[N-1:11]));
      check(rd_tag(), rdata, exp_rd());
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic rreg(logic [7:0] a, logic [31:0] exp, string tag);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
    #1; sel = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check("R1 pin_oe", 32'(poe), 0);
    check("R1 pin_o", 32'(pout), 0);
    check("R1 irqs", {20'b0, irq_high, irq_low}, 0);
    rreg(8'h18, 0, "R1 stat");
    rreg(8'h1C, 0, "R1 alt");

    // R3 / R11 upper bits
    wreg(8'h04, 32'hFFFF_FFFF);
    rreg(8'h04, 32'h0FFF_FFFF, "R11 upper bits dir");
    wreg(8'h04, 32'h0000_0000);
    // R4 set / clear
    wreg(8'h08, 32'h0F0F_00F3);
    wreg(8'h0C, 32'h0300_0011);
    check("R4 latch", 32'(pout), 32'h0C0F_00E2);
    rreg(8'h08, 0, "R4 set reads zero");
    wreg(8'h08, 0);
    wreg(8'h0C, 0);
    check("R4 zero writes", 32'(pout), 32'h0C0F_00E2);
    wreg(8'h0C, 32'h0FFF_FFFF);

    // R2 level pipeline
    ext = 28'hA5A_5A5A;
    idle(2);
    rreg(8'h00, 32'h0A5A_5A5A, "R2 level");
    wreg(8'h00, 32'hFFFF_FFFF);
    rreg(8'h00, 32'h0A5A_5A5A, "R2 write ignored");
    ext = '0;
    idle(4);

    // R5 edges
    wreg(8'h10, 32'h0000_000F);
    wreg(8'h14, 32'h0000_003C);
    ext = 28'h3F;
    idle(4);
    rreg(8'h18, 32'h0000_000F, "R5 rise");
    ext = '0;
    idle(4);
    rreg(8'h18, 32'h0000_003F, "R5 fall/both");
    // R6 sticky clear
    wreg(8'h18, 32'h0000_0005);
    rreg(8'h18, 32'h0000_003A, "R6 partial clear");
    wreg(8'h18, 0);
    rreg(8'h18, 32'h0000_003A, "R6 zero write");
    wreg(8'h18, 32'hFFFF_FFFF);
    rreg(8'h18, 0, "R6 clear all");

    // R7 clear colliding with new edge on pin 1 (rise and fall enabled)
    wreg(8'h10, 32'h2);
    wreg(8'h14, 32'h2);
    ext[1] = 1;
    idle(4);
    ext[1] = 0;
    idle(2);
    wreg(8'h18, 32'h2);
    rreg(8'h18, 32'h2, "R7 edge beats clear");
    wreg(8'h18, 32'hFFFF_FFFF);
    rreg(8'h18, 0, "R7 later clear");

    // R8 loop-back on output line 6
    wreg(8'h10, 32'h40);
    wreg(8'h04, 32'h40);
    wreg(8'h08, 32'h40);
    idle(3);
    rreg(8'h18, 32'h40, "R8 output edge");
    check("R9 low line 6", 32'(irq_low), 32'h40);
    wreg(8'h0C, 32'h40);
    wreg(8'h04, 0);
    wreg(8'h18, 32'hFFFF_FFFF);

    // R9 shared line
    wreg(8'h10, 32'h0010_1008);
    ext = 28'h0010_1000;
    idle(4);
    check("R9 high set", 32'(irq_high), 1);
    check("R9 low quiet", 32'(irq_low), 0);
    wreg(8'h18, 32'h0000_1000);
    check("R9 high still", 32'(irq_high), 1);
    wreg(8'h18, 32'h0010_0000);
    check("R9 high clear", 32'(irq_high), 0);
    ext[3] = 1;
    idle(4);
    check("R9 low line 3", 32'(irq_low), 32'h8);

    // R10 alternate storage
    wreg(8'h1C, 32'h0ABC_DEF1);
    rreg(8'h1C, 32'h0ABC_DEF1, "R10 storage");
    check("R10 no pin effect", 32'(poe), 0);

    // R11 unmapped
    wreg(8'h04, 32'h0000_0300);
    wreg(8'h20, 32'hFFFF_FFFF);
    wreg(8'hFC, 32'hFFFF_FFFF);
    rreg(8'h20, 0, "R11 unmapped read");
    rreg(8'h04, 32'h0000_0300, "R11 dir untouched");
    rreg(8'h1C, 32'h0ABC_DEF1, "R11 alt untouched");
    idle(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule